// File: doc/BRIEF.md
# Looping Display Command Controller

This block owns the command word of a display processor and decides when a memory transfer engine is told to run. Software writes an opcode, a write-protect bit, a repeat bit and an idle bit (ECL) into one 16-bit register. Writing the word with ECL cleared starts work. The controller then either launches the command once, or re-launches it at every vertical sync for as long as the repeat bit stays set. ECL goes back to 1 only when the controller has finished for good.

Each launch hands the engine a two-bit command code and a transfer address. The address is taken in one step from the two address registers at the moment of launch. A status register reflects the idle bit and holds two sticky event flags, one for "went idle" and one for "refused a reserved opcode". These flags clear when the status register is read, and they drive a maskable interrupt line. The sync output enable, and the write-protect qualifier passed to the engine, stay off until the first full-block load has completed after reset.

Top module: `dcmd_ctrl`

## Requirements
- R1: After reset, the command register reads 0x0001 and the status register reads 0x0001. The mask register has all its bits at 1 (reads 0x0003). `crt_oe`, `irq`, `eng_start` and `eng_wp` are 0.
- R2: The registers sit at byte addresses inside a 128-byte block: command 0x40, status 0x42, mask 0x44, address low 0x46, address high 0x48. In the command word, bits 15:8 hold the opcode, bit 2 write-protect, bit 1 repeat and bit 0 ECL. Bits 7:3 read 0. The address high register keeps only XADDR_W-16 bits. A read returns data on `cpu_rdata` in the cycle after `cpu_re` is sampled.
- R3: A command-register write with bit 0 = 0 and bit 1 = 0 while ECL = 1 produces a one-cycle `eng_start`, visible two clock edges after the write edge. `eng_cmd` equals opcode bits 1:0. When `eng_done` is sampled, ECL returns to 1 on that same edge.
- R4: A write with bit 1 = 1 and bit 0 = 0 waits for `vsync_pulse`. The command is launched on the edge where `vsync_pulse` is sampled, and again at each later `vsync_pulse` after `eng_done`. ECL stays 0 between runs.
- R5: Clearing the repeat bit while a command runs lets that run finish. ECL is set at its `eng_done`, and no further launch follows.
- R6: Clearing the repeat bit while waiting between vsyncs causes exactly one more launch at the next `vsync_pulse`. ECL is set at that run's `eng_done`.
- R7: An opcode outside 0x04 to 0x07 is never launched. At the point where it would start, the controller sets the reserved flag (status bit 2), clears the repeat bit and sets ECL.
- R8: Status bit 0 mirrors ECL. Status bit 1 sets whenever ECL is set by the controller, and status bit 2 is the reserved flag. Bits 1 and 2 clear on a status read (the read returns the value before clearing), and a new event in the same cycle wins. `irq` = (bit1 AND NOT mask bit0) OR (bit2 AND NOT mask bit1).
- R9: `eng_addr` = {address high, address low} as held at the launch edge. A CPU write to an address register on that edge, or during the run, does not alter it.
- R10: While ECL = 0, a command-register write changes only the repeat bit. Opcode, write-protect and ECL are unchanged.
- R11: `vsync_pulse` while a command runs launches nothing. `eng_done` while no command runs changes no state and raises no event.
- R12: `crt_oe` becomes 1 when a run of opcode 0x05 (full load) completes and stays 1 until reset. `eng_wp` = write-protect bit AND that same completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_re | input | 1 | Register read strobe |
| cpu_addr | input | REG_AW | Byte address within the register block |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Registered read data |
| vsync_pulse | input | 1 | One-cycle pulse at start of vertical sync |
| eng_start | output | 1 | One-cycle launch strobe to the transfer engine |
| eng_cmd | output | 2 | Command code: 0 load pair, 1 load all, 2 dump pair, 3 dump all |
| eng_addr | output | XADDR_W | Transfer address captured at launch |
| eng_wp | output | 1 | Write-protect qualifier for the engine's loads |
| eng_done | input | 1 | Engine completion strobe |
| crt_oe | output | 1 | Enable for sync and blank outputs |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with REG_AW = 7 and XADDR_W = 20. This leaves only four bits in the address high register, so a write of 0x00FA must read back as 0x000A and must also appear truncated in the captured transfer address. The narrow width also lets the bench check whole transfer addresses as exact 20-bit values. A behavioural model runs alongside the block and is compared on every clock. Directed sequences reach the awkward timings: an address write on the very edge of a launch, the repeat bit cleared both mid-run and between vsyncs, vsync arriving mid-run, and a reserved opcode in both one-shot and repeat form.

// File: rtl/dcmd_pkg.sv
package dcmd_pkg;

    localparam int WORD_W   = 16;
    localparam int OPCODE_W = 8;
    localparam int NUM_SRC  = 2;

    // Byte offsets in the register block; the command word offset is fixed.
    localparam int OFS_COMMAND = 'h40;
    localparam int OFS_STATUS  = 'h42;
    localparam int OFS_MASK    = 'h44;
    localparam int OFS_ADDR_LO = 'h46;
    localparam int OFS_ADDR_HI = 'h48;

    // Legal opcodes share the upper six bits 000001.
    localparam logic [OPCODE_W-3:0] LEGAL_FAMILY = 6'h01;
    localparam logic [OPCODE_W-1:0] OPC_FULL_LOAD = 8'h05;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_RUN,
        ST_ARMED
    } seq_state_e;

    typedef enum logic [1:0] {
        XC_LOAD_PAIR,
        XC_LOAD_ALL,
        XC_DUMP_PAIR,
        XC_DUMP_ALL
    } xfer_cmd_e;

    // Command word without its reserved bits.
    typedef struct packed {
        logic [OPCODE_W-1:0] op;
        logic                wp;
        logic                loop;
        logic                ecl;
    } cmd_ctl_t;

    // Sticky event sources; bit order matches the mask register.
    typedef struct packed {
        logic rsv;
        logic ecl_evt;
    } evt_flags_t;

    function automatic logic op_is_legal(input logic [OPCODE_W-1:0] op);
        return op[OPCODE_W-1:2] == LEGAL_FAMILY;
    endfunction

    function automatic xfer_cmd_e op_to_cmd(input logic [OPCODE_W-1:0] op);
        return xfer_cmd_e'(op[1:0]);
    endfunction

endpackage

// File: rtl/dcmd_regs.sv
module dcmd_regs
    import dcmd_pkg::*;
#(
    parameter int REG_AW  = 7,
    parameter int XADDR_W = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cpu_we,
    input  logic                 cpu_re,
    input  logic [REG_AW-1:0]    cpu_addr,
    input  logic [WORD_W-1:0]    cpu_wdata,
    input  cmd_ctl_t             ctl_view,
    input  evt_flags_t           flags,
    output logic [WORD_W-1:0]    cpu_rdata,
    output logic [NUM_SRC-1:0]   mask,
    output logic [XADDR_W-1:0]   xaddr,
    output logic                 cmd_wr,
    output cmd_ctl_t             cmd_wfields,
    output logic                 status_rd
);

    localparam int HI_W = XADDR_W - WORD_W;

    logic [WORD_W-1:0]  addr_lo_q;
    logic [HI_W-1:0]    addr_hi_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [WORD_W-1:0]  rd_mux;

    logic sel_cmd, sel_sts, sel_msk, sel_lo, sel_hi;

    assign sel_cmd = cpu_addr == REG_AW'(OFS_COMMAND);
    assign sel_sts = cpu_addr == REG_AW'(OFS_STATUS);
    assign sel_msk = cpu_addr == REG_AW'(OFS_MASK);
    assign sel_lo  = cpu_addr == REG_AW'(OFS_ADDR_LO);
    assign sel_hi  = cpu_addr == REG_AW'(OFS_ADDR_HI);

    assign cmd_wr    = cpu_we && sel_cmd;
    assign status_rd = cpu_re && sel_sts;

    assign cmd_wfields.op   = cpu_wdata[WORD_W-1:WORD_W-OPCODE_W];
    assign cmd_wfields.wp   = cpu_wdata[2];
    assign cmd_wfields.loop = cpu_wdata[1];
    assign cmd_wfields.ecl  = cpu_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_lo_q <= '0;
            addr_hi_q <= '0;
            mask_q    <= '1;
        end else if (cpu_we) begin
            if (sel_lo)  addr_lo_q <= cpu_wdata;
            if (sel_hi)  addr_hi_q <= cpu_wdata[HI_W-1:0];
            if (sel_msk) mask_q    <= cpu_wdata[NUM_SRC-1:0];
        end
    end

    assign mask  = mask_q;
    assign xaddr = {addr_hi_q, addr_lo_q};

    always_comb begin
        rd_mux = '0;
        if (sel_cmd) rd_mux = {ctl_view.op, 5'b0, ctl_view.wp, ctl_view.loop, ctl_view.ecl};
        if (sel_sts) rd_mux = {{(WORD_W-3){1'b0}}, flags.rsv, flags.ecl_evt, ctl_view.ecl};
        if (sel_msk) rd_mux = WORD_W'(mask_q);
        if (sel_lo)  rd_mux = addr_lo_q;
        if (sel_hi)  rd_mux = WORD_W'(addr_hi_q);
    end

    always_ff @(posedge clk) begin
        if (rst)         cpu_rdata <= '0;
        else if (cpu_re) cpu_rdata <= rd_mux;
    end

    // R1: mask leaves reset with every source disabled
    a_r1_mask_reset: assert property (@(posedge clk) $fell(rst) |-> (&mask_q));

endmodule

// File: rtl/dcmd_seq.sv
module dcmd_seq
    import dcmd_pkg::*;
#(
    parameter int XADDR_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_wr,
    input  cmd_ctl_t           cmd_wfields,
    input  logic               vsync_pulse,
    input  logic               eng_done,
    input  logic [XADDR_W-1:0] xaddr,
    output cmd_ctl_t           ctl_view,
    output logic               eng_start,
    output logic [1:0]         eng_cmd,
    output logic [XADDR_W-1:0] eng_addr,
    output logic               eng_wp,
    output logic               crt_oe,
    output logic               ev_ecl,
    output logic               ev_rsv
);

    seq_state_e          state_q;
    logic [OPCODE_W-1:0] op_q;
    logic                wp_q, loop_q, ecl_q, first_q;
    logic                go, legal, fin;

    assign go    = (state_q == ST_LAUNCH) || (state_q == ST_ARMED && vsync_pulse);
    assign legal = op_is_legal(op_q);
    assign fin   = (state_q == ST_RUN) && eng_done;

    assign ev_rsv = go && !legal;
    assign ev_ecl = ev_rsv || (fin && !loop_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            op_q      <= '0;
            wp_q      <= 1'b0;
            loop_q    <= 1'b0;
            ecl_q     <= 1'b1;
            first_q   <= 1'b0;
            eng_start <= 1'b0;
            eng_cmd   <= '0;
            eng_addr  <= '0;
        end else begin
            eng_start <= 1'b0;
            if (cmd_wr) begin
                if (ecl_q) begin
                    op_q   <= cmd_wfields.op;
                    wp_q   <= cmd_wfields.wp;
                    loop_q <= cmd_wfields.loop;
                    ecl_q  <= cmd_wfields.ecl;
                    if (!cmd_wfields.ecl)
                        state_q <= cmd_wfields.loop ? ST_ARMED : ST_LAUNCH;
                end else begin
                    loop_q <= cmd_wfields.loop;
                end
            end
            if (go) begin
                if (legal) begin
                    eng_start <= 1'b1;
                    eng_cmd   <= op_to_cmd(op_q);
                    eng_addr  <= xaddr;
                    state_q   <= ST_RUN;
                end else begin
                    state_q <= ST_IDLE;
                    ecl_q   <= 1'b1;
                    loop_q  <= 1'b0;
                end
            end
            if (fin) begin
                if (op_q == OPC_FULL_LOAD) first_q <= 1'b1;
                if (loop_q) begin
                    state_q <= ST_ARMED;
                end else begin
                    state_q <= ST_IDLE;
                    ecl_q   <= 1'b1;
                end
            end
        end
    end

    assign ctl_view.op   = op_q;
    assign ctl_view.wp   = wp_q;
    assign ctl_view.loop = loop_q;
    assign ctl_view.ecl  = ecl_q;

    assign crt_oe = first_q;
    assign eng_wp = wp_q && first_q;

    // R3: launch strobe lasts one cycle
    a_r3_start_single: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    // R3: idle bit and sequencer idle state agree
    a_r3_ecl_tracks_idle: assert property (@(posedge clk) disable iff (rst)
        ecl_q == (state_q == ST_IDLE));

    // R4: no launch happens while idle
    a_r4_start_needs_busy: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> (state_q == ST_RUN) && !ecl_q);

    // R7: a refused opcode is followed by no launch
    a_r7_refuse_no_start: assert property (@(posedge clk) disable iff (rst)
        ev_rsv |=> !eng_start && ecl_q && !loop_q);

    // R9: transfer address frozen for the whole run
    a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !eng_start) |-> $stable(eng_addr));

    // R12: sync output enable never drops once set
    a_r12_oe_sticky: assert property (@(posedge clk) disable iff (rst)
        crt_oe |=> crt_oe);

endmodule

// File: rtl/dcmd_irq.sv
module dcmd_irq
    import dcmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ev_ecl,
    input  logic               ev_rsv,
    input  logic               status_rd,
    input  logic [NUM_SRC-1:0] mask,
    output evt_flags_t         flags,
    output logic               irq
);

    evt_flags_t flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            if (status_rd) flags_q <= '0;
            if (ev_ecl)    flags_q.ecl_evt <= 1'b1;
            if (ev_rsv)    flags_q.rsv     <= 1'b1;
        end
    end

    assign flags = flags_q;
    assign irq   = |(flags_q & ~mask);

    // R8: a status read with no new event leaves the flags empty
    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !ev_ecl && !ev_rsv) |=> (flags_q == '0));

    // R8: a new event always lands in the flags
    a_r8_event_sticks: assert property (@(posedge clk) disable iff (rst)
        ev_rsv |=> flags_q.rsv && flags_q.ecl_evt);

endmodule

// File: rtl/dcmd_ctrl.sv
module dcmd_ctrl
    import dcmd_pkg::*;
#(
    parameter int REG_AW  = 7,
    parameter int XADDR_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_we,
    input  logic               cpu_re,
    input  logic [REG_AW-1:0]  cpu_addr,
    input  logic [15:0]        cpu_wdata,
    output logic [15:0]        cpu_rdata,
    input  logic               vsync_pulse,
    output logic               eng_start,
    output logic [1:0]         eng_cmd,
    output logic [XADDR_W-1:0] eng_addr,
    output logic               eng_wp,
    input  logic               eng_done,
    output logic               crt_oe,
    output logic               irq
);

    cmd_ctl_t           ctl_view;
    cmd_ctl_t           cmd_wfields;
    evt_flags_t         flags;
    logic [NUM_SRC-1:0] mask;
    logic [XADDR_W-1:0] xaddr;
    logic               cmd_wr, status_rd, ev_ecl, ev_rsv;

    dcmd_regs #(.REG_AW(REG_AW), .XADDR_W(XADDR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .cpu_we      (cpu_we),
        .cpu_re      (cpu_re),
        .cpu_addr    (cpu_addr),
        .cpu_wdata   (cpu_wdata),
        .ctl_view    (ctl_view),
        .flags       (flags),
        .cpu_rdata   (cpu_rdata),
        .mask        (mask),
        .xaddr       (xaddr),
        .cmd_wr      (cmd_wr),
        .cmd_wfields (cmd_wfields),
        .status_rd   (status_rd)
    );

    dcmd_seq #(.XADDR_W(XADDR_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .cmd_wr      (cmd_wr),
        .cmd_wfields (cmd_wfields),
        .vsync_pulse (vsync_pulse),
        .eng_done    (eng_done),
        .xaddr       (xaddr),
        .ctl_view    (ctl_view),
        .eng_start   (eng_start),
        .eng_cmd     (eng_cmd),
        .eng_addr    (eng_addr),
        .eng_wp      (eng_wp),
        .crt_oe      (crt_oe),
        .ev_ecl      (ev_ecl),
        .ev_rsv      (ev_rsv)
    );

    dcmd_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .ev_ecl    (ev_ecl),
        .ev_rsv    (ev_rsv),
        .status_rd (status_rd),
        .mask      (mask),
        .flags     (flags),
        .irq       (irq)
    );

endmodule

// File: tb/dcmd_ctrl_tb.sv
module dcmd_ctrl_tb;

    localparam int REG_AW  = 7;
    localparam int XADDR_W = 20;
    localparam int HI_W    = XADDR_W - 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cpu_we = 1'b0, cpu_re = 1'b0;
    logic [REG_AW-1:0]  cpu_addr = '0;
    logic [15:0]        cpu_wdata = '0;
    logic [15:0]        cpu_rdata;
    logic               vsync_pulse = 1'b0, eng_done = 1'b0;
    logic               eng_start, eng_wp, crt_oe, irq;
    logic [1:0]         eng_cmd;
    logic [XADDR_W-1:0] eng_addr;

    always #10 clk = ~clk;

    dcmd_ctrl #(.REG_AW(REG_AW), .XADDR_W(XADDR_W)) u_dut (
        .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_re(cpu_re),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .vsync_pulse(vsync_pulse), .eng_start(eng_start), .eng_cmd(eng_cmd),
        .eng_addr(eng_addr), .eng_wp(eng_wp), .eng_done(eng_done),
        .crt_oe(crt_oe), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference: 0 idle, 1 launch pending, 2 running, 3 waiting for vsync
    int                 m_st;
    logic [7:0]         m_op;
    logic               m_wp, m_loop, m_ecl, m_first, m_start, m_fe, m_fr;
    logic [1:0]         m_cmd, m_mask;
    logic [XADDR_W-1:0] m_addr;
    logic [15:0]        m_lo, m_rd;
    logic [HI_W-1:0]    m_hi;

    always begin
        @(posedge clk);
        if (rst) begin
            m_st = 0; m_op = 8'h00; m_wp = 1'b0; m_loop = 1'b0; m_ecl = 1'b1;
            m_first = 1'b0; m_start = 1'b0; m_fe = 1'b0; m_fr = 1'b0;
            m_cmd = 2'd0; m_mask = 2'b11; m_addr = '0; m_lo = '0; m_hi = '0; m_rd = '0;
        end else begin
            int                 o_st;
            logic               o_loop, ev_e, ev_r, legal;
            logic [7:0]         o_op;
            logic [XADDR_W-1:0] o_addr;
            o_st = m_st; o_loop = m_loop; o_op = m_op; o_addr = {m_hi, m_lo};
            ev_e = 1'b0; ev_r = 1'b0;
            if (cpu_re) begin
                case (cpu_addr)
                    7'h40: m_rd = {m_op, 5'b0, m_wp, m_loop, m_ecl};
                    7'h42: m_rd = {13'b0, m_fr, m_fe, m_ecl};
                    7'h44: m_rd = {14'b0, m_mask};
                    7'h46: m_rd = m_lo;
                    7'h48: m_rd = 16'(m_hi);
                    default: m_rd = 16'h0000;
                endcase
            end
            m_start = 1'b0;
            if (cpu_we) begin
                case (cpu_addr)
                    7'h40: begin
                        if (m_ecl) begin
                            m_op = cpu_wdata[15:8]; m_wp = cpu_wdata[2];
                            m_loop = cpu_wdata[1]; m_ecl = cpu_wdata[0];
                            if (!cpu_wdata[0]) m_st = cpu_wdata[1] ? 3 : 1;
                        end else begin
                            m_loop = cpu_wdata[1];
                        end
                    end
                    7'h44: m_mask = cpu_wdata[1:0];
                    7'h46: m_lo = cpu_wdata;
                    7'h48: m_hi = cpu_wdata[HI_W-1:0];
                    default: ;
                endcase
            end
            legal = (o_op >= 8'h04) && (o_op <= 8'h07);
            if (o_st == 1 || (o_st == 3 && vsync_pulse)) begin
                if (legal) begin
                    m_start = 1'b1; m_cmd = o_op[1:0]; m_addr = o_addr; m_st = 2;
                end else begin
                    m_st = 0; m_ecl = 1'b1; m_loop = 1'b0; ev_e = 1'b1; ev_r = 1'b1;
                end
            end
            if (o_st == 2 && eng_done) begin
                if (o_op == 8'h05) m_first = 1'b1;
                if (o_loop) m_st = 3;
                else begin m_st = 0; m_ecl = 1'b1; ev_e = 1'b1; end
            end
            if (cpu_re && cpu_addr == 7'h42) begin m_fe = 1'b0; m_fr = 1'b0; end
            if (ev_e) m_fe = 1'b1;
            if (ev_r) m_fr = 1'b1;
        end
        #5;
        if (!rst) begin
            check("R3 model eng_start", eng_start, m_start);
            check("R3 model eng_cmd", eng_cmd, m_cmd);
            check("R9 model eng_addr", eng_addr, m_addr);
            check("R12 model eng_wp", eng_wp, m_wp & m_first);
            check("R12 model crt_oe", crt_oe, m_first);
            check("R8 model irq", irq, |({m_fr, m_fe} & ~m_mask));
            check("R2 model cpu_rdata", cpu_rdata, m_rd);
        end
    end

    // All tasks are entered and left at a falling edge.
    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [15:0] d);
        cpu_re = 1'b1; cpu_addr = a;
        @(negedge clk);
        cpu_re = 1'b0;
        d = cpu_rdata;
    endtask

    task automatic vsync();
        vsync_pulse = 1'b1;
        @(negedge clk);
        vsync_pulse = 1'b0;
    endtask

    task automatic done();
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic wait_start(input string tag);
        logic seen = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (eng_start) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        check(tag, seen, 1'b1);
    endtask

    task automatic no_start(input string tag, input int n);
        int cnt = 0;
        for (int i = 0; i < n; i++) begin
            if (eng_start) cnt++;
            @(negedge clk);
        end
        check(tag, cnt, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(7'h40, d); check("R1 command after reset", d, 16'h0001);
        rd(7'h42, d); check("R1 status after reset", d, 16'h0001);
        rd(7'h44, d); check("R1 mask after reset", d, 16'h0003);
        check("R1 crt_oe", crt_oe, 1'b0);
        check("R1 irq", irq, 1'b0);
        check("R1 eng_wp", eng_wp, 1'b0);

        // R2 address registers and high-width truncation
        wr(7'h46, 16'h1234);
        wr(7'h48, 16'h00FA);
        rd(7'h48, d); check("R2 addr high truncated", d, 16'h000A);
        rd(7'h46, d); check("R2 addr low", d, 16'h1234);

        // R3 one-shot load pair
        wr(7'h40, 16'h0400);
        wait_start("R3 one-shot launches");
        check("R3 cmd code", eng_cmd, 2'd0);
        check("R9 captured address", eng_addr, 20'hA1234);
        rd(7'h40, d); check("R3 busy command word", d, 16'h0400);
        done();
        rd(7'h40, d); check("R3 idle after done", d, 16'h0401);
        rd(7'h42, d); check("R8 idle event flag", d, 16'h0003);
        rd(7'h42, d); check("R8 flag cleared by read", d, 16'h0001);
        check("R8 masked irq stays low", irq, 1'b0);

        // R12 first full load with write-protect requested
        wr(7'h44, 16'h0000);
        wr(7'h40, 16'h0504);
        wait_start("R12 full load launches");
        check("R12 wp held off before first load", eng_wp, 1'b0);
        check("R12 crt_oe before first load", crt_oe, 1'b0);
        done();
        check("R12 crt_oe after first load", crt_oe, 1'b1);
        check("R8 unmasked irq", irq, 1'b1);
        rd(7'h42, d); check("R8 status on read", d, 16'h0003);
        check("R8 irq after clear", irq, 1'b0);

        // R4 repeat on full load
        wr(7'h40, 16'h0506);
        no_start("R4 waits for vsync", 5);
        vsync();
        wait_start("R4 first repeat launch");
        check("R12 wp active after first load", eng_wp, 1'b1);
        done();
        rd(7'h40, d); check("R4 ECL stays low between runs", d, 16'h0506);
        check("R4 no idle event between runs", irq, 1'b0);
        vsync();
        wait_start("R4 second repeat launch");

        // R11, R9, R10, R5 during the run
        @(negedge clk);
        vsync();
        no_start("R11 vsync mid-run ignored", 3);
        wr(7'h46, 16'h0BCD);
        check("R9 address frozen mid-run", eng_addr, 20'hA1234);
        wr(7'h40, 16'h0700);
        rd(7'h40, d); check("R10 busy write touches only repeat", d, 16'h0504);
        done();
        rd(7'h40, d); check("R5 idle after final run", d, 16'h0505);
        vsync();
        no_start("R5 no launch after exit", 4);

        // R6 exit while waiting between vsyncs
        wr(7'h40, 16'h0602);
        vsync();
        wait_start("R6 repeat launch");
        done();
        wr(7'h40, 16'h0600);
        rd(7'h40, d); check("R6 repeat cleared while waiting", d, 16'h0600);
        no_start("R6 nothing before vsync", 4);
        vsync();
        wait_start("R6 one more launch");
        check("R6 cmd code dump pair", eng_cmd, 2'd2);
        check("R9 new address used", eng_addr, 20'hA0BCD);
        done();
        rd(7'h40, d); check("R6 idle after last run", d, 16'h0601);
        vsync();
        no_start("R6 no further launch", 4);
        rd(7'h42, d);

        // R7 reserved opcode in repeat mode and in one-shot mode
        wr(7'h40, 16'h0902);
        no_start("R7 waits", 3);
        vsync();
        no_start("R7 reserved never launched", 4);
        rd(7'h40, d); check("R7 repeat cleared and idle", d, 16'h0901);
        check("R7 irq raised", irq, 1'b1);
        rd(7'h42, d); check("R7 reserved flag", d, 16'h0007);
        wr(7'h40, 16'h0000);
        no_start("R7 one-shot reserved", 3);
        rd(7'h40, d); check("R7 one-shot idle", d, 16'h0001);
        rd(7'h42, d); check("R7 one-shot flag", d, 16'h0007);

        // R11 done strobe while idle
        done();
        rd(7'h42, d); check("R11 stray done no event", d, 16'h0001);
        rd(7'h40, d); check("R11 stray done no change", d, 16'h0001);

        // R9 address write on the launch edge
        wr(7'h40, 16'h0700);
        wr(7'h46, 16'h7777);
        wait_start("R9 launch with colliding write");
        check("R9 old address captured", eng_addr, 20'hA0BCD);
        check("R3 cmd code dump all", eng_cmd, 2'd3);
        done();
        rd(7'h46, d); check("R9 register took new value", d, 16'h7777);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule